// File: doc/BRIEF.md
# Signed and Unsigned Less-Than Comparator

This block compares two 16-bit operands and states whether the first is below the second. The comparison is either unsigned or two's-complement, chosen by a mode pin. All of the arithmetic runs through one ripple-carry adder.

That adder becomes a subtractor when the second operand is passed through XOR gates and the carry-in is raised. The add/subtract control is a port of its own, so the same datapath can also act as a plain adder or subtractor. The raw result, the carry-out and the two's-complement overflow of the adder are all brought out.

In signed mode the comparison never acts on the overflow flag. When the operands have different sign bits the subtraction could overflow, so the verdict is taken from the sign bits alone. When the sign bits match, overflow is impossible and the sign of the difference decides. In unsigned mode the verdict is the missing carry-out, which marks a borrow.

The block is purely combinational and has no clock, no reset and no handshake. Each output follows its inputs within the same cycle.

Top module: `lt_comparator`

## Requirements
- R1: With sub_en=0, result equals a+b modulo 2^16, and carry_out is bit 16 of the 17-bit sum.
- R2: With sub_en=1, result equals a-b modulo 2^16. carry_out is 1 exactly when a >= b as unsigned numbers, so carry_out=0 marks a borrow.
- R3: overflow is 1 exactly when the true two's-complement value of a+b (sub_en=0) or a-b (sub_en=1) lies outside -32768..32767.
- R4: A borrow on its own does not raise overflow. For example, 0x0000 minus 0x0001 gives result 0xFFFF with carry_out=0 and overflow=0.
- R5: With sub_en=1 and signed_mode=0, less_than is 1 exactly when a < b as unsigned numbers.
- R6: With sub_en=1 and signed_mode=1, less_than is 1 exactly when a < b as two's-complement numbers. This also holds where a-b overflows, for example a=0x8000 and b=0x7FFF gives 1.
- R7: With sub_en=1, signed_mode=1 and differing bit 15 of a and b, less_than equals bit 15 of a.
- R8: With sub_en=1 and a equal to b, less_than is 0 in both modes.
- R9: With sub_en=0, less_than is 0 whatever the operands and the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| sub_en | input | 1 | 1 subtracts b from a, 0 adds them |
| signed_mode | input | 1 | 1 compares as two's complement, 0 as unsigned |
| result | output | 16 | Sum or difference from the shared adder |
| carry_out | output | 1 | Carry out of the adder's top bit |
| overflow | output | 1 | Two's-complement overflow of the adder |
| less_than | output | 1 | 1 when a is below b in the selected mode |

## Verification
Every output depends only on the current inputs, so each result is due in the cycle its stimulus is applied, with no register on the way. The bench changes the inputs at the falling clock edge and reads all four outputs one nanosecond later. It never waits for an extra edge and never samples at an edge. Each scenario task works out its expected values with the simulator's wide integer arithmetic, not with the adder's gate structure. The tasks cover overflowing and non-overflowing signed pairs, borrow cases, equal operands and the gated add mode.

// File: rtl/lt_cmp_pkg.sv
`timescale 1ns/1ps
package lt_cmp_pkg;
  localparam int unsigned OPW = 16;
  localparam int unsigned MSB = OPW - 1;
  typedef logic [OPW-1:0] word_t;

  typedef struct packed {
    logic carry;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/lt_operand_cond.sv
`timescale 1ns/1ps
module lt_operand_cond
  import lt_cmp_pkg::*;
(
  input  word_t b_in,
  input  logic  sub_en,
  output word_t b_cond,
  output logic  cin
);
  // XOR with the subtract control gives one's complement, and carry-in adds the one
  always_comb begin
    b_cond = b_in ^ {OPW{sub_en}};
    cin    = sub_en;
  end
endmodule

// File: rtl/lt_ripple_adder.sv
`timescale 1ns/1ps
module lt_ripple_adder
  import lt_cmp_pkg::*;
(
  input  word_t x,
  input  word_t y,
  input  logic  cin,
  output word_t s,
  output logic  cout
);
  logic [OPW:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < OPW; i++) begin : g_bit
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign cout = c[OPW];
endmodule

// File: rtl/lt_flag_unit.sv
`timescale 1ns/1ps
module lt_flag_unit
  import lt_cmp_pkg::*;
(
  input  word_t  x,
  input  word_t  y,
  input  word_t  s,
  input  logic   cout,
  output flags_t flags
);
  // Overflow: the adder inputs agree in sign and the sum disagrees
  always_comb begin
    flags.carry = cout;
    flags.ovf   = (x[MSB] ~^ y[MSB]) & (s[MSB] ^ x[MSB]);
  end
endmodule

// File: rtl/lt_decide.sv
`timescale 1ns/1ps
module lt_decide
  import lt_cmp_pkg::*;
(
  input  logic a_msb,
  input  logic b_msb,
  input  logic diff_msb,
  input  logic cout,
  input  logic sub_en,
  input  logic signed_mode,
  output logic lt
);
  logic signed_lt;
  logic unsigned_lt;

  always_comb begin
    // Different signs could overflow, so the sign bits decide
    if (a_msb != b_msb) signed_lt = a_msb;
    else                signed_lt = diff_msb;
    unsigned_lt = ~cout;
    lt = sub_en & (signed_mode ? signed_lt : unsigned_lt);
  end
endmodule

// File: rtl/lt_comparator.sv
`timescale 1ns/1ps
module lt_comparator
  import lt_cmp_pkg::*;
(
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic        sub_en,
  input  logic        signed_mode,
  output logic [15:0] result,
  output logic        carry_out,
  output logic        overflow,
  output logic        less_than
);
  word_t  b_cond;
  word_t  sum;
  logic   cin;
  logic   cout;
  flags_t flags;

  lt_operand_cond i_cond (
    .b_in   (b),
    .sub_en (sub_en),
    .b_cond (b_cond),
    .cin    (cin)
  );

  lt_ripple_adder i_adder (
    .x    (a),
    .y    (b_cond),
    .cin  (cin),
    .s    (sum),
    .cout (cout)
  );

  lt_flag_unit i_flags (
    .x     (a),
    .y     (b_cond),
    .s     (sum),
    .cout  (cout),
    .flags (flags)
  );

  lt_decide i_decide (
    .a_msb       (a[MSB]),
    .b_msb       (b[MSB]),
    .diff_msb    (sum[MSB]),
    .cout        (cout),
    .sub_en      (sub_en),
    .signed_mode (signed_mode),
    .lt          (less_than)
  );

  assign result    = sum;
  assign carry_out = flags.carry;
  assign overflow  = flags.ovf;
endmodule

// File: rtl/lt_comparator_checker.sv
`timescale 1ns/1ps
module lt_comparator_checker (
  input logic [15:0] a,
  input logic [15:0] b,
  input logic        sub_en,
  input logic        signed_mode,
  input logic [15:0] result,
  input logic        carry_out,
  input logic        overflow,
  input logic        less_than
);
  logic [16:0] wide_add;
  logic        known;

  always_comb begin
    wide_add = {1'b0, a} + {1'b0, b};
    known    = !$isunknown({a, b, sub_en, signed_mode});
    if (known && !sub_en) begin
      a_r1_add_sum: assert ({carry_out, result} == wide_add);
      a_r9_add_no_lt: assert (less_than == 1'b0);
    end
    if (known && sub_en) begin
      a_r2_sub_carry: assert (carry_out == (a >= b));
      a_r8_equal_not_lt: assert (!(a == b) || !less_than);
      if (signed_mode) begin
        a_r6_signed_lt: assert (less_than == ($signed(a) < $signed(b)));
      end else begin
        a_r5_unsigned_lt: assert (less_than == (a < b));
      end
    end
  end
endmodule

bind lt_comparator lt_comparator_checker i_chk (.*);

// File: tb/test_lt_comparator.sv
`timescale 1ns/1ps
module test_lt_comparator;
  logic        clk = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        sub_en = 1'b0;
  logic        signed_mode = 1'b0;
  logic [15:0] result;
  logic        carry_out;
  logic        overflow;
  logic        less_than;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  lt_comparator i_lt_comparator (
    .a(a), .b(b), .sub_en(sub_en), .signed_mode(signed_mode),
    .result(result), .carry_out(carry_out), .overflow(overflow),
    .less_than(less_than)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h sub=%0d sgn=%0d actual=%0h expected=%0h",
               req, what, a, b, sub_en, signed_mode, act, exp);
    end
  endtask

  // Drive at falling edge, sample 1 ns later: combinational, due same cycle
  task automatic apply(input logic [15:0] ta, input logic [15:0] tb_, input logic op, input logic sm);
    longint sa, sb, sres;
    logic [16:0] wide;
    int exp_lt;
    @(negedge clk);
    a = ta; b = tb_; sub_en = op; signed_mode = sm;
    #1;
    sa = longint'($signed(ta));
    sb = longint'($signed(tb_));
    if (op) begin
      wide = {1'b0, ta} + {1'b0, ~tb_} + 17'd1;
      sres = sa - sb;
      chk("R2", "result", int'(result), int'(wide[15:0]));
      chk("R2", "carry", int'(carry_out), int'(ta >= tb_));
      if (sm) begin
        exp_lt = int'(sa < sb);
        chk("R6", "lt", int'(less_than), exp_lt);
        if (ta[15] != tb_[15]) chk("R7", "lt", int'(less_than), int'(ta[15]));
      end else begin
        exp_lt = int'(ta < tb_);
        chk("R5", "lt", int'(less_than), exp_lt);
      end
      if (ta == tb_) chk("R8", "lt", int'(less_than), 0);
    end else begin
      wide = {1'b0, ta} + {1'b0, tb_};
      sres = sa + sb;
      chk("R1", "result", int'(result), int'(wide[15:0]));
      chk("R1", "carry", int'(carry_out), int'(wide[16]));
      chk("R9", "lt", int'(less_than), 0);
    end
    chk("R3", "ovf", int'(overflow), int'(sres > 32767 || sres < -32768));
  endtask

  task automatic t_reset_state;
    @(negedge clk); #1;
    chk("R1", "idle result", int'(result), 0);
    chk("R9", "idle lt", int'(less_than), 0);
  endtask

  task automatic t_add;
    apply(16'h1234, 16'h0FF0, 0, 0);
    apply(16'hFFFF, 16'h0001, 0, 1);
    apply(16'h7FFF, 16'h0001, 0, 1);
    apply(16'h8000, 16'h8000, 0, 0);
    apply(16'h0003, 16'h0009, 0, 1);
  endtask

  task automatic t_borrow_no_ovf;  // R4
    apply(16'h0000, 16'h0001, 1, 0);
    chk("R4", "result", int'(result), 16'hFFFF);
    chk("R4", "carry", int'(carry_out), 0);
    chk("R4", "ovf", int'(overflow), 0);
  endtask

  task automatic t_unsigned;
    apply(16'h0005, 16'h0009, 1, 0);
    apply(16'h0009, 16'h0005, 1, 0);
    apply(16'hFFFF, 16'h0000, 1, 0);
    apply(16'h7FFF, 16'h8000, 1, 0);
    apply(16'h8000, 16'h7FFF, 1, 0);
  endtask

  task automatic t_signed_overflow;
    apply(16'h8000, 16'h7FFF, 1, 1);
    chk("R6", "min vs max", int'(less_than), 1);
    apply(16'h7FFF, 16'h8000, 1, 1);
    chk("R6", "max vs min", int'(less_than), 0);
    apply(16'h8000, 16'h0001, 1, 1);
    apply(16'h4000, 16'hC000, 1, 1);
    apply(16'hC000, 16'h4000, 1, 1);
  endtask

  task automatic t_signed_same_sign;
    apply(16'hFFFE, 16'hFFFF, 1, 1);
    apply(16'hFFFF, 16'hFFFE, 1, 1);
    apply(16'h0010, 16'h0100, 1, 1);
    apply(16'h7FFF, 16'h0000, 1, 1);
  endtask

  task automatic t_equal;
    apply(16'h0000, 16'h0000, 1, 0);
    apply(16'h8000, 16'h8000, 1, 1);
    apply(16'hA5A5, 16'hA5A5, 1, 0);
    apply(16'hFFFF, 16'hFFFF, 1, 1);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 64; i++) begin
      apply(16'(i * 16'h0413), 16'(16'hF00D - i * 16'h0519), 1'(i % 3 == 0), 1'(i % 2));
    end
  endtask

  initial begin
    t_reset_state();
    t_add();
    t_borrow_no_ovf();
    t_unsigned();
    t_signed_overflow();
    t_signed_same_sign();
    t_equal();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule